// File: doc/BRIEF.md
# Float-to-Unsigned Integer Converter

This block takes a 32-bit single-precision floating-point bit pattern and returns its integer part as a 32-bit unsigned number. It is meant for telemetry readings that are always positive, such as fan speeds reported in floating-point form. The fraction is always truncated. Zero, negative numbers and magnitudes below one all give zero. Exponents too large for the output give all ones.

The input word comes with a valid strobe. The block sorts each word into one of four classes:

- `CLS_ZERO`: zero, a set sign bit, or an unbiased exponent below zero.
- `CLS_SATURATE`: unbiased exponent above 30.
- `CLS_NARROW`: unbiased exponent from 0 to 23. The significand with its hidden one is shifted right.
- `CLS_WIDE`: unbiased exponent from 24 to 30. The significand is shifted left.

The class is worked out combinationally. One register stage captures the result and the delayed strobe. The output holds its last value while no new word is presented.

Top module: `f2u_conv`

## Requirements
- R1: An input of all zeros, or any input with bit 31 (sign) set, gives an output of 0.
- R2: The unbiased exponent is bits 30:23 taken as an unsigned number minus 127. The mantissa is bits 22:0.
- R3: When the unbiased exponent is negative, the output is 0. This includes subnormals and values below 1.0.
- R4: For unbiased exponent e from 0 to 23, the output is (1 << e) + (mantissa >> (23 − e)). The fraction is truncated, not rounded.
- R5: For unbiased exponent e from 24 to 30, the output is (1 << e) | (mantissa << (e − 23)).
- R6: For an unbiased exponent above 30, the output is 0xFFFFFFFF. This includes the all-ones exponent field.
- R7: `out_valid` equals `in_valid` delayed by exactly one clock. A result appears on `out_value` one clock after its word is presented.
- R8: While `in_valid` is low, `out_value` keeps its previous value.
- R9: During reset, `out_valid` is 0 and `out_value` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Marks `in_bits` as a word to convert |
| in_bits | input | 32 | Single-precision bit pattern |
| out_valid | output | 1 | Result strobe, one clock after `in_valid` |
| out_value | output | 32 | Truncated unsigned integer result |

## Verification
Every result is due exactly one rising edge after its word is presented. There is one register between `in_bits` and `out_value`, and one between `in_valid` and `out_valid`. The bench drives each word on a falling edge and waits through the next rising edge. It then samples `out_value` and `out_valid` at the following falling edge, compared against a reference model computed in the bench. For the hold requirement, the bench drops the strobe with a different word on the input. It then samples one and two clocks later, to confirm that nothing moved.

// File: rtl/f2u_pkg.sv
package f2u_pkg;
    // Conversion class of one input word
    typedef enum logic [1:0] {
        CLS_ZERO     = 2'd0,
        CLS_SATURATE = 2'd1,
        CLS_NARROW   = 2'd2,
        CLS_WIDE     = 2'd3
    } f2u_class_e;
endpackage

// File: rtl/f2u_classify.sv
module f2u_classify
    import f2u_pkg::*;
#(
    parameter int EXP_W = 8,
    parameter int MAN_W = 23,
    parameter int OUT_W = 32,
    localparam int WORD_W = 1 + EXP_W + MAN_W,
    localparam int SH_W = $clog2(OUT_W)
) (
    input  logic [WORD_W-1:0] word_i,
    output f2u_class_e        cls_o,
    output logic [SH_W-1:0]   shamt_o
);
    localparam int BIAS    = (1 << (EXP_W - 1)) - 1;
    localparam int MAX_EXP = OUT_W - 2;

    logic             sign_bit;
    logic [EXP_W-1:0] exp_field;
    int               unb_exp;

    assign sign_bit  = word_i[WORD_W-1];
    assign exp_field = word_i[WORD_W-2 -: EXP_W];

    always_comb begin
        unb_exp = int'(exp_field) - BIAS;
        cls_o   = CLS_ZERO;
        shamt_o = '0;
        if (word_i == '0 || sign_bit || unb_exp < 0) begin
            cls_o = CLS_ZERO;
        end else if (unb_exp > MAX_EXP) begin
            cls_o = CLS_SATURATE;
        end else if (unb_exp <= MAN_W) begin
            cls_o   = CLS_NARROW;
            shamt_o = SH_W'(MAN_W - unb_exp);
        end else begin
            cls_o   = CLS_WIDE;
            shamt_o = SH_W'(unb_exp - MAN_W);
        end
    end
endmodule

// File: rtl/f2u_shift.sv
module f2u_shift
    import f2u_pkg::*;
#(
    parameter int MAN_W = 23,
    parameter int OUT_W = 32,
    localparam int SH_W = $clog2(OUT_W)
) (
    input  f2u_class_e       cls_i,
    input  logic [SH_W-1:0]  shamt_i,
    input  logic [MAN_W-1:0] man_i,
    output logic [OUT_W-1:0] value_o
);
    logic [OUT_W-1:0] signif;

    // hidden one placed above the mantissa, zero-extended to the output width
    assign signif = {{(OUT_W - MAN_W - 1){1'b0}}, 1'b1, man_i};

    always_comb begin
        unique case (cls_i)
            CLS_ZERO:     value_o = '0;
            CLS_SATURATE: value_o = '1;
            CLS_NARROW:   value_o = signif >> shamt_i;
            CLS_WIDE:     value_o = signif << shamt_i;
            default:      value_o = '0;
        endcase
    end
endmodule

// File: rtl/f2u_conv.sv
module f2u_conv
    import f2u_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        in_valid,
    input  logic [31:0] in_bits,
    output logic        out_valid,
    output logic [31:0] out_value
);
    localparam int EXP_W = 8;
    localparam int MAN_W = 23;
    localparam int OUT_W = 32;
    localparam int SH_W  = $clog2(OUT_W);

    f2u_class_e       cls;
    logic [SH_W-1:0]  shamt;
    logic [OUT_W-1:0] next_value;

    f2u_classify #(.EXP_W(EXP_W), .MAN_W(MAN_W), .OUT_W(OUT_W)) classify_i (
        .word_i  (in_bits),
        .cls_o   (cls),
        .shamt_o (shamt)
    );

    f2u_shift #(.MAN_W(MAN_W), .OUT_W(OUT_W)) shift_i (
        .cls_i   (cls),
        .shamt_i (shamt),
        .man_i   (in_bits[MAN_W-1:0]),
        .value_o (next_value)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_value <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                out_value <= next_value;
            end
        end
    end
endmodule

// File: rtl/f2u_conv_chk.sv
module f2u_conv_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        in_valid,
    input logic [31:0] in_bits,
    input logic        out_valid,
    input logic [31:0] out_value
);
    // R7: strobe follows one clock later
    a_r7_valid_delay: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    a_r7_idle_delay: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

    // R1: sign bit forces zero
    a_r1_negative_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_bits[31]) |=> (out_value == 32'd0));

    // R3: magnitude below one gives zero
    a_r3_small_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_bits[30:23] < 8'd127) |=> (out_value == 32'd0));

    // R6: large exponents saturate
    a_r6_saturate: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !in_bits[31] && in_bits[30:23] > 8'd157) |=> (out_value == 32'hFFFF_FFFF));

    // R4: integral values in the narrow range convert exactly
    a_r4_pow2_narrow: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !in_bits[31] && in_bits[22:0] == 23'd0
         && in_bits[30:23] >= 8'd127 && in_bits[30:23] <= 8'd150)
        |=> ($countones(out_value) == 1));

    // R8: output holds while idle
    a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(out_value));

    // R9: reset values
    always_comb begin
        if (!rst_n) begin
            a_r9_reset_state: assert (out_valid == 1'b0 && out_value == 32'd0);
        end
    end
endmodule

bind f2u_conv f2u_conv_chk chk_i (.*);

// File: tb/f2u_conv_tb_top.sv
module f2u_conv_tb_top;
    logic        clk;
    logic        rst_n;
    logic        in_valid;
    logic [31:0] in_bits;
    logic        out_valid;
    logic [31:0] out_value;

    int n_checks;
    int n_fails;

    f2u_conv dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_bits   (in_bits),
        .out_valid (out_valid),
        .out_value (out_value)
    );

    initial clk = 1'b0;
    always #4 clk = ~clk;

    function automatic logic [31:0] ref_model(input logic [31:0] d);
        int          e;
        logic [31:0] fr;
        if (d == 32'd0 || d[31]) return 32'd0;
        e  = int'(d[30:23]) - 127;
        fr = {9'd0, d[22:0]};
        if (e < 0) return 32'd0;
        if (e > 30) return 32'hFFFF_FFFF;
        if (e > 23) return (32'd1 << e) | (fr << (e - 23));
        return (32'd1 << e) + (fr >> (23 - e));
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual=%08h expected=%08h", tag, act, exp);
        end
    endtask

    // drive one word on a falling edge; sample at the falling edge after the capture edge
    task automatic convert(input string tag, input logic [31:0] word, input logic [31:0] exp);
        @(negedge clk);
        in_valid = 1'b1;
        in_bits  = word;
        @(negedge clk);
        in_valid = 1'b0;
        check({tag, " value"}, out_value, exp);
        check("R7 strobe", {31'd0, out_valid}, 32'd1);
    endtask

    task automatic test_reset();
        rst_n = 1'b0;
        in_valid = 1'b0;
        in_bits = 32'h4000_0000;
        repeat (3) @(negedge clk);
        check("R9 reset out_valid", {31'd0, out_valid}, 32'd0);
        check("R9 reset out_value", out_value, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic test_zero_sign();
        convert("R1 zero", 32'h0000_0000, 32'd0);
        convert("R1 minus one", 32'hBF80_0000, 32'd0);
        convert("R1 minus big", 32'hCF00_0000, 32'd0);
        convert("R1 minus zero", 32'h8000_0000, 32'd0);
    endtask

    task automatic test_fraction();
        convert("R3 0.999", 32'h3F7F_FFFF, 32'd0);
        convert("R3 subnormal", 32'h0000_0001, 32'd0);
        convert("R3 0.5", 32'h3F00_0000, 32'd0);
    endtask

    task automatic test_narrow();
        convert("R4 one", 32'h3F80_0000, 32'd1);
        convert("R4 pi", 32'h4049_0FDB, 32'd3);
        convert("R4 1000.0", 32'h447A_0000, 32'd1000);
        convert("R4 1.99", 32'h3FFF_FFFF, 32'd1);
        convert("R4 exp23 top", 32'h4B7F_FFFF, 32'd16777215);
        convert("R2 field split", 32'h4580_0400, ref_model(32'h4580_0400));
    endtask

    task automatic test_wide();
        convert("R5 exp24", 32'h4B80_0001, 32'd16777218);
        convert("R5 exp30 top", 32'h4EFF_FFFF, 32'h7FFF_FF80);
        convert("R5 exp30 one", 32'h4E80_0000, 32'h4000_0000);
    endtask

    task automatic test_saturate();
        convert("R6 exp31", 32'h4F00_0000, 32'hFFFF_FFFF);
        convert("R6 infinity", 32'h7F80_0000, 32'hFFFF_FFFF);
        convert("R6 nan", 32'h7FC0_0001, 32'hFFFF_FFFF);
    endtask

    task automatic test_hold();
        convert("R8 seed", 32'h4120_0000, 32'd10);
        @(negedge clk);
        in_valid = 1'b0;
        in_bits  = 32'h4F00_0000;
        @(negedge clk);
        check("R8 hold value", out_value, 32'd10);
        check("R7 idle strobe", {31'd0, out_valid}, 32'd0);
        @(negedge clk);
        check("R8 hold value later", out_value, 32'd10);
    endtask

    task automatic test_back_to_back();
        @(negedge clk);
        in_valid = 1'b1;
        in_bits  = 32'h4080_0000;
        @(negedge clk);
        check("R7 stream first", out_value, 32'd4);
        in_bits = 32'h4100_0000;
        @(negedge clk);
        check("R7 stream second", out_value, 32'd8);
        in_valid = 1'b0;
    endtask

    task automatic test_random();
        for (int i = 0; i < 300; i++) begin
            logic [31:0] w;
            w = $urandom;
            if (i % 3 == 0) w[30:23] = 8'(120 + (i % 40));
            convert("R4 R5 random", w, ref_model(w));
        end
    endtask

    initial begin
        n_checks = 0;
        n_fails  = 0;
        test_reset();
        test_zero_sign();
        test_fraction();
        test_narrow();
        test_wide();
        test_saturate();
        test_hold();
        test_back_to_back();
        test_random();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog: actual=expired expected=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end
endmodule